// File: doc/BRIEF.md
# Temperature Readout Snapshot Lock

This block keeps the most recent raw results of two on-die temperature sensors in four byte-wide registers that a host reads through a simple address and read-strobe port. A multi-byte result is spread over more than one register, so the block makes sure the host never sees a torn reading. The first read of any temperature register freezes all four registers. They thaw only once every one of the four addresses has been read at least once. The host may read them in any order.

Each sensor supplies a sample strobe together with its raw value. The sensor enables come from an external configuration register, and both are low after reset. A disabled sensor's strobe is ignored. The values are passed through without offset or gain correction. A build parameter selects what happens to a sample that arrives while the registers are frozen. In one variant it is dropped. In the other it is held in a one-deep per-sensor shadow register and written at the release edge.

Top module: `temp_snap_lock`

## Requirements
- R1: After reset all four readout registers read 0 and the registers are not frozen.
- R2: `rd_data_o` combinationally shows the register selected by `rd_addr_i`. Address 2k holds bits [7:0] of sensor k. Address 2k+1 holds bits [15:8] of sensor k.
- R3: While not frozen, an enabled sensor's sample with `smp_vld_i[k]` high at a clock edge is readable from the next cycle.
- R4: A read strobe (`rd_i` high at a clock edge) to any address freezes all four registers from that same edge onward. Samples at that edge or later do not reach the registers while frozen.
- R5: The freeze is released at the edge where the last not-yet-read address is read. The order of the reads does not matter. A repeated read of an already-read address does not count toward release.
- R6: After a release the read-tracking state is empty, so samples update the registers again and the next read starts a new freeze.
- R7: With `SHADOW_EN`=0, samples that arrive during a freeze are discarded. After release the registers keep their pre-freeze values until a new sample arrives.
- R8: With `SHADOW_EN`=1, the latest enabled sample per sensor during a freeze is written at the release edge. A sample that arrives on the release edge itself takes precedence.
- R9: A sensor whose enable in `sens_en_i` is low ignores its strobe and keeps its last value.
- R10: Register contents are the raw sample bits, unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sens_en_i | input | NUM_SENS (2) | Per-sensor enable from configuration |
| smp_vld_i | input | NUM_SENS (2) | Per-sensor new-sample strobe |
| smp_data_i | input | NUM_SENS*SAMPLE_W (32) | Raw samples, sensor k at [k*16 +: 16] |
| rd_i | input | 1 | Register read strobe |
| rd_addr_i | input | AW (2) | Register address |
| rd_data_o | output | 8 | Read data of the addressed register |

## Verification
On every cycle the assertions check several rules. Frozen registers stay stable. A read that does not release the lock leaves the block frozen. A duplicate read leaves the read mask unchanged. A release empties the mask. Disabled sensors hold their values. An unfrozen enabled sample is captured. Only the bench scenarios can show the data-level outcome across a whole freeze. They sweep all 24 read orders with duplicate reads, samples landing at the freeze edge, mid-freeze and on the release edge. They also show which value each variant presents afterwards and that the byte mapping holds for every address.

// File: rtl/temp_lock_pkg.sv
`timescale 1ns/10ps
package temp_lock_pkg;
  localparam int unsigned REG_W = 8;
  typedef logic [REG_W-1:0] reg_byte_t;
endpackage

// File: rtl/temp_lock_ctrl.sv
`timescale 1ns/10ps
module temp_lock_ctrl #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned AW       = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          lock_o,
  output logic          release_o
);
  logic                frozen_q;
  logic [NUM_REGS-1:0] seen_q, seen_nxt;

  // freeze takes effect on the edge of the first read
  assign lock_o    = frozen_q | rd_i;
  assign seen_nxt  = seen_q | (rd_i ? (NUM_REGS'(1) << rd_addr_i) : '0);
  assign release_o = lock_o & (&seen_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      seen_q   <= '0;
    end else if (release_o) begin
      frozen_q <= 1'b0;
      seen_q   <= '0;
    end else if (lock_o) begin
      frozen_q <= 1'b1;
      seen_q   <= seen_nxt;
    end
  end

  assert_idle_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen_q |-> (seen_q == '0));
  assert_release_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> (!frozen_q && seen_q == '0));
  assert_freeze_on_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !release_o) |=> frozen_q);
  assert_release_needs_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frozen_q) |-> $past(rd_i));
  assert_dup_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && rd_i && seen_q[rd_addr_i]) |=> (frozen_q && seen_q == $past(seen_q)));
endmodule

// File: rtl/temp_sens_slot.sv
`timescale 1ns/10ps
module temp_sens_slot #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter bit          SHADOW_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                vld_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                lock_i,
  input  logic                release_i,
  output logic [SAMPLE_W-1:0] val_o
);
  logic [SAMPLE_W-1:0] val_q, shad_q;
  logic                shad_vld_q;
  logic                take_new;

  assign take_new = en_i & vld_i;
  assign val_o    = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (!lock_i) begin
      if (take_new) val_q <= data_i;
    end else if (release_i) begin
      // a sample on the release edge is newer than the shadow
      if (take_new)        val_q <= data_i;
      else if (shad_vld_q) val_q <= shad_q;
    end
  end

  generate
    if (SHADOW_EN) begin : g_shadow
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          shad_q     <= '0;
          shad_vld_q <= 1'b0;
        end else if (release_i) begin
          shad_vld_q <= 1'b0;
        end else if (lock_i && take_new) begin
          shad_q     <= data_i;
          shad_vld_q <= 1'b1;
        end
      end
    end else begin : g_drop
      assign shad_q     = '0;
      assign shad_vld_q = 1'b0;

      assert_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (release_i && !take_new) |=> $stable(val_q));
    end
  endgenerate

  assert_hold_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !release_i) |=> $stable(val_q));
  assert_disabled_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !(release_i && shad_vld_q)) |=> $stable(val_q));
  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && en_i && vld_i) |=> (val_q == $past(data_i)));
endmodule

// File: rtl/temp_snap_lock.sv
`timescale 1ns/10ps
module temp_snap_lock #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned NUM_SENS  = 2,
  parameter bit          SHADOW_EN = 1'b1,
  localparam int unsigned BYTES_PER = (SAMPLE_W + temp_lock_pkg::REG_W - 1) / temp_lock_pkg::REG_W,
  localparam int unsigned NUM_REGS  = NUM_SENS * BYTES_PER,
  localparam int unsigned AW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SENS-1:0]          sens_en_i,
  input  logic [NUM_SENS-1:0]          smp_vld_i,
  input  logic [NUM_SENS*SAMPLE_W-1:0] smp_data_i,
  input  logic                         rd_i,
  input  logic [AW-1:0]                rd_addr_i,
  output temp_lock_pkg::reg_byte_t     rd_data_o
);
  import temp_lock_pkg::*;

  localparam int unsigned SLOT_W = BYTES_PER * REG_W;

  logic                       lock, release_w;
  logic [NUM_REGS*REG_W-1:0]  val_flat;

  temp_lock_ctrl #(.NUM_REGS(NUM_REGS), .AW(AW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .rd_addr_i (rd_addr_i),
    .lock_o    (lock),
    .release_o (release_w)
  );

  generate
    for (genvar k = 0; k < NUM_SENS; k++) begin : g_sens
      logic [SAMPLE_W-1:0] val;
      temp_sens_slot #(.SAMPLE_W(SAMPLE_W), .SHADOW_EN(SHADOW_EN)) u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (sens_en_i[k]),
        .vld_i     (smp_vld_i[k]),
        .data_i    (smp_data_i[k*SAMPLE_W +: SAMPLE_W]),
        .lock_i    (lock),
        .release_i (release_w),
        .val_o     (val)
      );
      assign val_flat[k*SLOT_W +: SLOT_W] = SLOT_W'(val);
    end
  endgenerate

  assign rd_data_o = val_flat[int'(rd_addr_i)*REG_W +: REG_W];

  assert_frozen_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !release_w) |=> $stable(val_flat));
endmodule

// File: tb/sim_temp_snap_lock.sv
`timescale 1ns/10ps
module sim_temp_snap_lock;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sens_en_i = 2'b00;
  logic [1:0]  smp_vld_i = 2'b00;
  logic [31:0] smp_data_i = '0;
  logic        rd_i = 1'b0;
  logic [1:0]  rd_addr_i = 2'd0;
  logic [7:0]  rd0, rd1;

  int errors = 0;
  int checks = 0;
  int seq = 0;
  bit done = 1'b0;

  // model: index 0 = shadow variant (u0), 1 = drop variant (u1)
  logic [15:0] mv [2][2];
  logic [15:0] msh [2];
  logic        mshv [2];
  logic        mfrz;
  logic [3:0]  mmask;

  always #2 clk_i = ~clk_i;

  temp_snap_lock #(.SHADOW_EN(1'b1)) u0 (
    .clk_i, .rst_ni, .sens_en_i, .smp_vld_i, .smp_data_i, .rd_i, .rd_addr_i, .rd_data_o(rd0));
  temp_snap_lock #(.SHADOW_EN(1'b0)) u1 (
    .clk_i, .rst_ni, .sens_en_i, .smp_vld_i, .smp_data_i, .rd_i, .rd_addr_i, .rd_data_o(rd1));

  function automatic logic [7:0] exp_byte(int m, logic [1:0] a);
    logic [15:0] w = mv[m][a[1]];
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [15:0] mk(int n);
    return 16'(n * 16'h1357 + 16'h0A5C);
  endfunction

  task automatic cmp(int m, logic [1:0] a, string tag);
    logic [7:0] got = (m == 0) ? rd0 : rd1;
    logic [7:0] ex  = exp_byte(m, a);
    checks++;
    if (got !== ex) begin
      errors++;
      $display("FAIL %s variant=%0s addr=%0d actual=%h expected=%h",
               tag, (m == 0) ? "shadow" : "drop", a, got, ex);
    end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 4; a++) begin
      rd_addr_i = 2'(a);
      #0.2;
      cmp(0, 2'(a), tag);
      cmp(1, 2'(a), tag);
    end
  endtask

  task automatic model_edge(logic rd, logic [1:0] a, logic [1:0] v, logic [15:0] d0, logic [15:0] d1);
    logic       lock = mfrz | rd;
    logic [3:0] mn   = mmask | (rd ? (4'b1 << a) : 4'b0);
    logic       rel  = lock && (mn == 4'hF);
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 2; k++) begin
        logic [15:0] dk   = (k == 0) ? d0 : d1;
        logic        take = sens_en_i[k] && v[k];
        if (!lock) begin
          if (take) mv[m][k] = dk;
        end else if (rel) begin
          if (take) mv[m][k] = dk;
          else if (m == 0 && mshv[k]) mv[m][k] = msh[k];
        end
        if (m == 0) begin
          if (rel) mshv[k] = 1'b0;
          else if (lock && take) begin msh[k] = dk; mshv[k] = 1'b1; end
        end
      end
    end
    mmask = rel ? 4'h0 : (lock ? mn : mmask);
    mfrz  = lock && !rel;
  endtask

  // called just after a falling edge
  task automatic step(logic rd, logic [1:0] a, logic [1:0] v, string tag);
    logic [15:0] d0 = mk(seq);
    logic [15:0] d1 = mk(seq + 1000);
    seq++;
    rd_i = rd; rd_addr_i = a; smp_vld_i = v; smp_data_i = {d1, d0};
    #0.2;
    cmp(0, a, "R2");
    cmp(1, a, "R2");
    @(posedge clk_i);
    model_edge(rd, a, v, d0, d1);
    @(negedge clk_i);
    rd_i = 1'b0; smp_vld_i = 2'b00;
    check_all(tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) for (int k = 0; k < 2; k++) mv[m][k] = '0;
    for (int k = 0; k < 2; k++) begin msh[k] = '0; mshv[k] = 1'b0; end
    mfrz = 1'b0; mmask = 4'h0;

    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // both disabled: strobes ignored
    step(0, 2'd0, 2'b11, "R9");
    sens_en_i = 2'b11;
    step(0, 2'd0, 2'b11, "R3 R10");
    step(0, 2'd0, 2'b01, "R3");

    // every read order, with duplicates and samples at each stage
    for (int p0 = 0; p0 < 4; p0++)
      for (int p1 = 0; p1 < 4; p1++)
        for (int p2 = 0; p2 < 4; p2++)
          for (int p3 = 0; p3 < 4; p3++) begin
            if (p0 == p1 || p0 == p2 || p0 == p3 || p1 == p2 || p1 == p3 || p2 == p3) continue;
            step(1, 2'(p0), 2'b11, "R4");
            step(0, 2'd0, 2'(1 + (p1 & 1)), "R7 R8");
            step(1, 2'(p0), 2'b10, "R5 dup");
            step(1, 2'(p1), 2'b00, "R5");
            step(1, 2'(p1), 2'b00, "R5 dup");
            step(1, 2'(p2), (p3 & 1) ? 2'b01 : 2'b00, "R5 R8");
            step(1, 2'(p3), (p2 == 0) ? 2'b11 : 2'b00, "R5 R7 R8");
            step(0, 2'd0, (p0 == 3) ? 2'b11 : 2'b00, "R6");
          end

    // one sensor disabled, unfrozen and through a freeze
    sens_en_i = 2'b01;
    step(0, 2'd0, 2'b11, "R9");
    step(1, 2'd2, 2'b10, "R9");
    step(1, 2'd0, 2'b10, "R9");
    step(1, 2'd1, 2'b00, "R9");
    step(1, 2'd3, 2'b10, "R9");
    sens_en_i = 2'b10;
    step(0, 2'd0, 2'b11, "R9 R3");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule